// File: doc/BRIEF.md
# Load-Store Byte-Lane Aligner and Merger

This unit sits in the memory data path of a 32-bit core. It handles unsigned word, halfword and byte accesses. For a load, the aligner takes the word fetched from memory and moves the addressed byte or halfword down to the low lanes, filling the upper lanes with zeros. For a store, the merger takes the register word and places its low byte or halfword into the addressed lanes of the previous memory word, so that the surrounding bytes are kept.

Each request carries an operation code, a byte offset, a source word and the previous memory word. The unit first packs every legal operation and offset pair into a selector of four base-3 digits. It then decodes that selector, checks that the selector is consistent, and drives the lane multiplexers from the decoded result. The result is registered: it appears one clock after the request strobe, together with a load flag and the recovered shift amounts. A pair that is not legal raises an error flag in place of a valid result.

Top module: `lane_steer_unit`

## Requirements
- R1: While `rst` is high at a clock edge, and on the first edge after it, `out_valid`, `out_err`, `out_is_load`, `out_ld_shift`, `out_st_shift` and `out_data` are all zero.
- R2: `in_op[2]` selects store (1) or load (0). `in_op[1:0]` gives the size: 0 byte, 1 halfword, 2 word, 3 reserved. A legal request with `in_valid` high gives `out_valid` high on the next clock edge, with `out_err` low.
- R3: A request is illegal when its size is 3, when a word access has a nonzero offset, or when a halfword access has an odd offset. An illegal request gives `out_err` high and `out_valid` low on the next edge, and leaves `out_data` unchanged.
- R4: A byte load returns the source byte at the offset in bits 7:0 and zeros in bits 31:8.
- R5: A halfword load returns source bytes offset and offset+1 in bits 15:0 and zeros in bits 31:16.
- R6: A word load or a word store returns the source word unchanged.
- R7: A byte store returns the previous word with the byte at the offset replaced by source bits 7:0.
- R8: A halfword store returns the previous word with bytes offset and offset+1 replaced by source bits 15:0.
- R9: `out_is_load` is high for exactly the seven legal load cases.
- R10: `out_ld_shift` equals the offset for loads and is 0 for stores. `out_st_shift` equals the offset for stores and is 0 for loads.
- R11: A clock edge with `in_valid` low gives `out_valid` and `out_err` low and keeps `out_data` unchanged.
- R12: Every selector the encoder produces for a legal pair has each digit in 0..2 and a digit sum of 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Bit 2 selects store; bits 1:0 give the size |
| in_offset | input | 2 | Byte offset within the word |
| in_src | input | 32 | Memory word for loads, register word for stores |
| in_prev | input | 32 | Previous memory word, used by stores |
| out_valid | output | 1 | Result valid, one clock after a legal request |
| out_err | output | 1 | The request was an illegal pair |
| out_data | output | 32 | Aligned load result or merged store word |
| out_is_load | output | 1 | The result comes from a load |
| out_ld_shift | output | 2 | Load shift amount |
| out_st_shift | output | 2 | Store shift amount |

## Verification
A wrong selector digit sends the request to a different case. The error shows up in the response one clock after the strobe: bytes sit in the wrong lanes, zero fill is missing, a previous byte is lost, or the load flag or shift has the wrong value. The sweep covers every operation code, every offset and several distinct data patterns, so each of the fourteen decode paths and each illegal pair produces a distinct result that is checked in that cycle. Idle cycles that follow each request show any result register that fails to hold its value.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  localparam int DIGITS  = 4;
  localparam int DIGIT_W = 2;
  localparam int SEL_W   = DIGITS * DIGIT_W;

  typedef struct packed {
    logic       ok;
    logic       is_load;
    logic [1:0] size;
    logic [1:0] shift;
  } dec_t;
endpackage

// File: rtl/sel_encoder.sv
module sel_encoder
  import lane_steer_pkg::*;
(
  input  logic             is_store,
  input  logic [1:0]       size,
  input  logic [1:0]       offset,
  output logic [SEL_W-1:0] sel
);
  // digit k occupies bits 2k+1:2k
  always_comb begin
    sel = '0;
    unique case ({is_store, size, offset})
      {1'b0, SZ_WORD, 2'd0}: sel = 8'h02;
      {1'b0, SZ_HALF, 2'd0}: sel = 8'h08;
      {1'b0, SZ_HALF, 2'd2}: sel = 8'h20;
      {1'b0, SZ_BYTE, 2'd0}: sel = 8'h80;
      {1'b0, SZ_BYTE, 2'd1}: sel = 8'h01;
      {1'b0, SZ_BYTE, 2'd2}: sel = 8'h04;
      {1'b0, SZ_BYTE, 2'd3}: sel = 8'h10;
      {1'b1, SZ_WORD, 2'd0}: sel = 8'h40;
      {1'b1, SZ_HALF, 2'd0}: sel = 8'h05;
      {1'b1, SZ_HALF, 2'd2}: sel = 8'h11;
      {1'b1, SZ_BYTE, 2'd0}: sel = 8'h41;
      {1'b1, SZ_BYTE, 2'd1}: sel = 8'h14;
      {1'b1, SZ_BYTE, 2'd2}: sel = 8'h44;
      {1'b1, SZ_BYTE, 2'd3}: sel = 8'h50;
      default:               sel = '0;
    endcase
  end
endmodule

// File: rtl/sel_decoder.sv
module sel_decoder
  import lane_steer_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output logic             code_ok,
  output dec_t             dec
);
  logic [DIGITS-1:0] digit_in_range;
  logic [3:0]        part_sum [DIGITS+1];
  dec_t              raw;

  assign part_sum[0] = '0;
  generate
    for (genvar k = 0; k < DIGITS; k++) begin : g_digit
      logic [DIGIT_W-1:0] d;
      assign d                 = sel[k*DIGIT_W +: DIGIT_W];
      assign digit_in_range[k] = (d != 2'd3);
      assign part_sum[k+1]     = part_sum[k] + {2'b00, d};
    end
  endgenerate

  assign code_ok = (&digit_in_range) &&
                   (part_sum[DIGITS] == 4'd1 || part_sum[DIGITS] == 4'd2);

  always_comb begin
    raw = '0;
    unique case (sel)
      8'h02: raw = '{ok: 1'b1, is_load: 1'b1, size: SZ_WORD, shift: 2'd0};
      8'h08: raw = '{ok: 1'b1, is_load: 1'b1, size: SZ_HALF, shift: 2'd0};
      8'h20: raw = '{ok: 1'b1, is_load: 1'b1, size: SZ_HALF, shift: 2'd2};
      8'h80: raw = '{ok: 1'b1, is_load: 1'b1, size: SZ_BYTE, shift: 2'd0};
      8'h01: raw = '{ok: 1'b1, is_load: 1'b1, size: SZ_BYTE, shift: 2'd1};
      8'h04: raw = '{ok: 1'b1, is_load: 1'b1, size: SZ_BYTE, shift: 2'd2};
      8'h10: raw = '{ok: 1'b1, is_load: 1'b1, size: SZ_BYTE, shift: 2'd3};
      8'h40: raw = '{ok: 1'b1, is_load: 1'b0, size: SZ_WORD, shift: 2'd0};
      8'h05: raw = '{ok: 1'b1, is_load: 1'b0, size: SZ_HALF, shift: 2'd0};
      8'h11: raw = '{ok: 1'b1, is_load: 1'b0, size: SZ_HALF, shift: 2'd2};
      8'h41: raw = '{ok: 1'b1, is_load: 1'b0, size: SZ_BYTE, shift: 2'd0};
      8'h14: raw = '{ok: 1'b1, is_load: 1'b0, size: SZ_BYTE, shift: 2'd1};
      8'h44: raw = '{ok: 1'b1, is_load: 1'b0, size: SZ_BYTE, shift: 2'd2};
      8'h50: raw = '{ok: 1'b1, is_load: 1'b0, size: SZ_BYTE, shift: 2'd3};
      default: raw = '0;
    endcase
  end

  // a case is taken only if the digit checks agree with the table
  always_comb begin
    dec    = raw;
    dec.ok = raw.ok && code_ok;
  end
endmodule

// File: rtl/lane_mux.sv
module lane_mux
  import lane_steer_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  dec_t              dec,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] prev,
  output logic [DATA_W-1:0] result
);
  logic [7:0] src_b  [LANES];
  logic [7:0] prev_b [LANES];

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [1:0] ld_idx;
      logic [1:0] st_idx;
      logic       in_half;
      logic [7:0] ld_byte;
      logic [7:0] st_byte;

      assign src_b[i]  = src[i*8 +: 8];
      assign prev_b[i] = prev[i*8 +: 8];
      assign ld_idx    = dec.shift + 2'(i);
      assign st_idx    = 2'(i) - dec.shift;
      assign in_half   = (2'(i) == dec.shift) || (2'(i) == dec.shift + 2'd1);

      always_comb begin
        unique case (dec.size)
          SZ_BYTE: ld_byte = (i == 0) ? src_b[dec.shift] : 8'h00;
          SZ_HALF: ld_byte = (i < 2) ? src_b[ld_idx] : 8'h00;
          default: ld_byte = src_b[i];
        endcase
        unique case (dec.size)
          SZ_BYTE: st_byte = (2'(i) == dec.shift) ? src_b[0] : prev_b[i];
          SZ_HALF: st_byte = in_half ? src_b[st_idx] : prev_b[i];
          default: st_byte = src_b[i];
        endcase
      end

      assign result[i*8 +: 8] = dec.is_load ? ld_byte : st_byte;
    end
  endgenerate
endmodule

// File: rtl/lane_steer_unit.sv
module lane_steer_unit
  import lane_steer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic [1:0]        in_offset,
  input  logic [DATA_W-1:0] in_src,
  input  logic [DATA_W-1:0] in_prev,
  output logic              out_valid,
  output logic              out_err,
  output logic [DATA_W-1:0] out_data,
  output logic              out_is_load,
  output logic [1:0]        out_ld_shift,
  output logic [1:0]        out_st_shift
);
  logic [SEL_W-1:0]  sel;
  logic              code_ok;
  dec_t              dec;
  logic [DATA_W-1:0] merged;

  sel_encoder u_enc (
    .is_store (in_op[2]),
    .size     (in_op[1:0]),
    .offset   (in_offset),
    .sel      (sel)
  );

  sel_decoder u_dec (
    .sel     (sel),
    .code_ok (code_ok),
    .dec     (dec)
  );

  lane_mux #(.DATA_W(DATA_W)) u_mux (
    .dec    (dec),
    .src    (in_src),
    .prev   (in_prev),
    .result (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_err      <= 1'b0;
      out_data     <= '0;
      out_is_load  <= 1'b0;
      out_ld_shift <= '0;
      out_st_shift <= '0;
    end else begin
      out_valid <= in_valid && dec.ok;
      out_err   <= in_valid && !dec.ok;
      if (in_valid && dec.ok) begin
        out_data     <= merged;
        out_is_load  <= dec.is_load;
        out_ld_shift <= dec.is_load ? dec.shift : 2'd0;
        out_st_shift <= dec.is_load ? 2'd0 : dec.shift;
      end
    end
  end

  // R12
  sel_digits_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel != '0) |-> code_ok);

  // R2
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R3
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_err));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_err && $stable(out_data)));

  // R10
  shift_side_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_is_load ? (out_st_shift == 2'd0) : (out_ld_shift == 2'd0)));
endmodule

// File: tb/lane_steer_unit_tb.sv
`timescale 1ns/1ps
module lane_steer_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  in_op;
  logic [1:0]  in_offset;
  logic [31:0] in_src;
  logic [31:0] in_prev;
  logic        out_valid;
  logic        out_err;
  logic [31:0] out_data;
  logic        out_is_load;
  logic [1:0]  out_ld_shift;
  logic [1:0]  out_st_shift;

  int checks = 0;
  int errors = 0;
  logic [31:0] last_data;

  always #4 clk = ~clk;

  lane_steer_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_offset(in_offset), .in_src(in_src), .in_prev(in_prev),
    .out_valid(out_valid), .out_err(out_err), .out_data(out_data),
    .out_is_load(out_is_load), .out_ld_shift(out_ld_shift),
    .out_st_shift(out_st_shift)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic legal(input logic [2:0] op, input logic [1:0] off);
    case (op[1:0])
      2'd0:    return 1'b1;
      2'd1:    return off[0] == 1'b0;
      2'd2:    return off == 2'd0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] model(input logic [2:0] op, input logic [1:0] off,
                                        input logic [31:0] s, input logic [31:0] p);
    logic [31:0] r;
    int o;
    o = int'(off);
    r = 32'h0;
    if (op[1:0] == 2'd2) r = s;
    else if (!op[2]) begin
      if (op[1:0] == 2'd0) r[7:0] = s[8*o +: 8];
      else r[15:0] = s[8*o +: 16];
    end else begin
      r = p;
      if (op[1:0] == 2'd0) r[8*o +: 8] = s[7:0];
      else r[8*o +: 16] = s[15:0];
    end
    return r;
  endfunction

  task automatic run_one(input logic [2:0] op, input logic [1:0] off,
                         input logic [31:0] s, input logic [31:0] p);
    logic ok;
    logic [31:0] exp;
    ok  = legal(op, off);
    exp = model(op, off, s, p);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_offset = off; in_src = s; in_prev = p;
    @(negedge clk);
    in_valid = 1'b0; in_src = ~s; in_prev = ~p;
    if (ok) begin
      chk(out_valid && !out_err, "R2 legal request valid", {30'd0, out_valid, out_err}, 32'h2);
      if (op[1:0] == 2'd2)
        chk(out_data == exp, "R6 word passthrough", out_data, exp);
      else if (!op[2] && op[1:0] == 2'd0)
        chk(out_data == exp, "R4 byte load", out_data, exp);
      else if (!op[2])
        chk(out_data == exp, "R5 halfword load", out_data, exp);
      else if (op[1:0] == 2'd0)
        chk(out_data == exp, "R7 byte store", out_data, exp);
      else
        chk(out_data == exp, "R8 halfword store", out_data, exp);
      chk(out_is_load == !op[2], "R9 load flag", {31'd0, out_is_load}, {31'd0, !op[2]});
      chk(out_ld_shift == (op[2] ? 2'd0 : off), "R10 load shift",
          {30'd0, out_ld_shift}, {30'd0, op[2] ? 2'd0 : off});
      chk(out_st_shift == (op[2] ? off : 2'd0), "R10 store shift",
          {30'd0, out_st_shift}, {30'd0, op[2] ? off : 2'd0});
      last_data = exp;
    end else begin
      chk(out_err && !out_valid, "R3 illegal flagged", {30'd0, out_valid, out_err}, 32'h1);
      chk(out_data == last_data, "R3 illegal leaves data", out_data, last_data);
    end
    @(negedge clk);
    chk(!out_valid && !out_err, "R11 idle no strobe", {30'd0, out_valid, out_err}, 32'h0);
    chk(out_data == last_data, "R11 idle holds data", out_data, last_data);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pats_s [3];
    logic [31:0] pats_p [3];
    pats_s[0] = 32'h44332211; pats_p[0] = 32'hDDCCBBAA;
    pats_s[1] = 32'hFF80017E; pats_p[1] = 32'h00000000;
    pats_s[2] = 32'h0F1E2D3C; pats_p[2] = 32'hFFFFFFFF;
    rst = 1'b1; in_valid = 1'b1; in_op = 3'd2; in_offset = 2'd0;
    in_src = 32'hCAFEF00D; in_prev = 32'h12345678;
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_err && out_data == 32'h0 && !out_is_load &&
        out_ld_shift == 2'd0 && out_st_shift == 2'd0, "R1 reset state", out_data, 32'h0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !out_err && out_data == 32'h0, "R1 after reset", out_data, 32'h0);
    last_data = 32'h0;
    for (int p = 0; p < 3; p++)
      for (int op = 0; op < 8; op++)
        for (int off = 0; off < 4; off++)
          run_one(3'(op), 2'(off), pats_s[p], pats_p[p]);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule